// File: doc/BRIEF.md
# Memory-Access and Write-Back Pipeline Tail

This block is the last two stages of an in-order integer pipeline. The first stage, memory-access, registers what the execute stage hands over: the result, the program counter, the instruction word, the bubble flag and the exception status. This one-cycle hold exists because the data memory registers its address and control on the clock edge that ends execute. Its read data and acknowledge therefore only appear while the load sits in the memory-access stage.

The second stage, write-back, captures either the carried result or the load data. Load data is lane-shifted and sign- or zero-extended before it is captured. From its register the stage drives the register file write port. Both stages also drive their contents out to the decode and execute stages for bypass and hazard control.

When a load has reached memory-access and no acknowledge has arrived, the block raises a stall. It then holds the load in place and inserts a bubble into write-back. A flush empties both the stage being entered and the stage being left.

Top module: `mwb_backend`

## Requirements
- R1: After reset `mem_bubble` and `wb_bubble` are 1, `wb_we` is 0 and `stall` is 0.
- R2: In a cycle without stall or flush, the memory-access stage captures `ex_result`, `ex_pc`, `ex_instr`, `ex_bubble` and `ex_exception`, and shows them on the `mem_*` outputs after the clock edge.
- R3: A non-load instruction moves from memory-access to write-back unchanged in one cycle. Its result, pc, instruction, bubble and exception appear on the `wb_*` outputs.
- R4: `wb_we` is 1 only when all of these hold: write-back holds no bubble, its exception status is all zero, and `wb_dst` is nonzero. The instruction must also write a register, meaning opcode bits [6:0] are one of 0000011, 0010011, 0010111, 0110011, 0110111, 1100111, 1101111, 0011011 or 0111011, or are 1110011 with funct3 (bits [14:12]) nonzero.
- R5: `wb_dst` equals bits [11:7] of `wb_instr`.
- R6: A load (opcode 0000011) in memory-access with no bubble, no exception and `dmem_ack` low raises `stall` in the same cycle. The load stays in memory-access, and write-back receives a bubble.
- R7: A load with `dmem_ack` high delivers the read data to `wb_result` in the next cycle. The data is shifted right by 8 times the low two bits of the carried result, which is the load address.
- R8: funct3 selects the extension: 000 sign-extends a byte, 001 sign-extends a halfword, 010 takes the whole word, 100 zero-extends a byte and 101 zero-extends a halfword.
- R9: With `flush` high, memory-access becomes a bubble and the instruction leaving memory-access enters write-back as a bubble. No register write results from either instruction.
- R10: An instruction with nonzero exception status never causes a register write and never raises `stall`. Its exception status is carried to `wb_exception`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Kill the instructions entering and leaving memory-access |
| ex_result | input | 32 | Execute result (the effective address for loads) |
| ex_pc | input | 32 | Execute program counter |
| ex_instr | input | 32 | Execute instruction word |
| ex_bubble | input | 1 | Execute slot is empty |
| ex_exception | input | 4 | Execute exception status, nonzero means an exception |
| dmem_q | input | 32 | Data memory read data |
| dmem_ack | input | 1 | Data memory read acknowledge |
| stall | output | 1 | Load waiting for acknowledge, hold earlier stages |
| mem_result | output | 32 | Memory-access result, fed back |
| mem_instr | output | 32 | Memory-access instruction, fed back |
| mem_pc | output | 32 | Memory-access program counter |
| mem_bubble | output | 1 | Memory-access bubble, fed back |
| mem_exception | output | 4 | Memory-access exception status, fed back |
| wb_result | output | 32 | Register file write data, also fed back |
| wb_dst | output | 5 | Register file destination index |
| wb_we | output | 1 | Register file write enable |
| wb_pc | output | 32 | Write-back program counter |
| wb_instr | output | 32 | Write-back instruction, fed back |
| wb_bubble | output | 1 | Write-back bubble, fed back |
| wb_exception | output | 4 | Write-back exception status, fed back |

## Verification
Two events can land in one cycle: a flush and a load that is still waiting for its acknowledge. The flush must win, so the stall drops, the waiting load is discarded and write-back sees a bubble. Random stimulus produces this overlap by raising flush in about one cycle in twenty while loads are common and acknowledges are withheld about a third of the time. A reference model kept in the bench predicts `stall`, both stage contents and the write port for every cycle, and each prediction is compared with the outputs.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [6:0] {
    OPC_LOAD   = 7'b0000011,
    OPC_OPIMM  = 7'b0010011,
    OPC_AUIPC  = 7'b0010111,
    OPC_OP     = 7'b0110011,
    OPC_LUI    = 7'b0110111,
    OPC_JALR   = 7'b1100111,
    OPC_JAL    = 7'b1101111,
    OPC_OPIMMW = 7'b0011011,
    OPC_OPW    = 7'b0111011,
    OPC_SYSTEM = 7'b1110011
  } opcode_e;

  localparam int RD_LSB = 7;
  localparam int RD_W   = 5;

  function automatic logic op_is_load(input logic [31:0] instr);
    return instr[6:0] == OPC_LOAD;
  endfunction

  function automatic logic op_writes_rd(input logic [31:0] instr);
    logic w;
    case (instr[6:0])
      OPC_LOAD, OPC_OPIMM, OPC_AUIPC, OPC_OP, OPC_LUI,
      OPC_JALR, OPC_JAL, OPC_OPIMMW, OPC_OPW: w = 1'b1;
      OPC_SYSTEM: w = |instr[14:12];
      default:    w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mwb_mem_stage.sv
module mwb_mem_stage #(
  parameter int XLEN  = 32,
  parameter int EXC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             stall,
  input  logic [XLEN-1:0]  ex_result,
  input  logic [XLEN-1:0]  ex_pc,
  input  logic [31:0]      ex_instr,
  input  logic             ex_bubble,
  input  logic [EXC_W-1:0] ex_exception,
  output logic [XLEN-1:0]  mem_result,
  output logic [XLEN-1:0]  mem_pc,
  output logic [31:0]      mem_instr,
  output logic             mem_bubble,
  output logic [EXC_W-1:0] mem_exception
);

  logic             en;
  logic             bub_nxt;
  logic [EXC_W-1:0] exc_nxt;

  always_comb begin
    en      = flush | ~stall;
    bub_nxt = flush ? 1'b1 : ex_bubble;
    exc_nxt = flush ? '0 : ex_exception;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_result    <= '0;
      mem_pc        <= '0;
      mem_instr     <= '0;
      mem_bubble    <= 1'b1;
      mem_exception <= '0;
    end else if (en) begin
      mem_result    <= ex_result;
      mem_pc        <= ex_pc;
      mem_instr     <= ex_instr;
      mem_bubble    <= bub_nxt;
      mem_exception <= exc_nxt;
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush) |=> (mem_pc == $past(ex_pc) && mem_instr == $past(ex_instr)
                            && mem_bubble == $past(ex_bubble)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(mem_instr) && $stable(mem_result) && !mem_bubble));

  a_r9_flush_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mem_bubble && mem_exception == '0));

endmodule

// File: rtl/mwb_load_align.sv
module mwb_load_align #(
  parameter int XLEN = 32,
  localparam int LSB_W = $clog2(XLEN/8)
) (
  input  logic [XLEN-1:0]  rdata,
  input  logic [LSB_W-1:0] addr_lo,
  input  logic [2:0]       funct3,
  output logic [XLEN-1:0]  ldata
);

  logic [XLEN-1:0] shifted;
  logic            unsgn;
  logic [XLEN-1:0] word_ext;

  assign shifted = rdata >> {addr_lo, 3'b000};
  assign unsgn   = funct3[2];

  generate
    if (XLEN > 32) begin : g_wide
      assign word_ext = {{(XLEN-32){~unsgn & shifted[31]}}, shifted[31:0]};
    end else begin : g_narrow
      assign word_ext = shifted;
    end
  endgenerate

  always_comb begin
    case (funct3[1:0])
      2'b00:   ldata = {{(XLEN-8){~unsgn & shifted[7]}}, shifted[7:0]};
      2'b01:   ldata = {{(XLEN-16){~unsgn & shifted[15]}}, shifted[15:0]};
      2'b10:   ldata = word_ext;
      default: ldata = shifted;
    endcase
  end

endmodule

// File: rtl/mwb_wb_stage.sv
module mwb_wb_stage
  import mwb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EXC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             mem_load,
  input  logic [XLEN-1:0]  load_data,
  input  logic [XLEN-1:0]  mem_result,
  input  logic [XLEN-1:0]  mem_pc,
  input  logic [31:0]      mem_instr,
  input  logic             mem_bubble,
  input  logic [EXC_W-1:0] mem_exception,
  output logic [XLEN-1:0]  wb_result,
  output logic [RD_W-1:0]  wb_dst,
  output logic             wb_we,
  output logic [XLEN-1:0]  wb_pc,
  output logic [31:0]      wb_instr,
  output logic             wb_bubble,
  output logic [EXC_W-1:0] wb_exception
);

  logic             en;
  logic [XLEN-1:0]  res_nxt;
  logic             bub_nxt;
  logic [EXC_W-1:0] exc_nxt;

  always_comb begin
    en      = 1'b1;
    res_nxt = mem_load ? load_data : mem_result;
    bub_nxt = mem_bubble | kill;
    exc_nxt = kill ? '0 : mem_exception;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_result    <= '0;
      wb_pc        <= '0;
      wb_instr     <= '0;
      wb_bubble    <= 1'b1;
      wb_exception <= '0;
    end else if (en) begin
      wb_result    <= res_nxt;
      wb_pc        <= mem_pc;
      wb_instr     <= mem_instr;
      wb_bubble    <= bub_nxt;
      wb_exception <= exc_nxt;
    end
  end

  always_comb begin
    wb_dst = wb_instr[RD_LSB +: RD_W];
    wb_we  = ~wb_bubble & ~|wb_exception & op_writes_rd(wb_instr) & |wb_dst;
  end

  a_r9_kill_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !wb_we);

  a_r10_exc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_exception != '0) |=> !wb_we);

endmodule

// File: rtl/mwb_backend.sv
module mwb_backend
  import mwb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EXC_W = 4,
  localparam int LSB_W = $clog2(XLEN/8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [XLEN-1:0]  ex_result,
  input  logic [XLEN-1:0]  ex_pc,
  input  logic [31:0]      ex_instr,
  input  logic             ex_bubble,
  input  logic [EXC_W-1:0] ex_exception,
  input  logic [XLEN-1:0]  dmem_q,
  input  logic             dmem_ack,
  output logic             stall,
  output logic [XLEN-1:0]  mem_result,
  output logic [31:0]      mem_instr,
  output logic [XLEN-1:0]  mem_pc,
  output logic             mem_bubble,
  output logic [EXC_W-1:0] mem_exception,
  output logic [XLEN-1:0]  wb_result,
  output logic [RD_W-1:0]  wb_dst,
  output logic             wb_we,
  output logic [XLEN-1:0]  wb_pc,
  output logic [31:0]      wb_instr,
  output logic             wb_bubble,
  output logic [EXC_W-1:0] wb_exception
);

  logic            mem_load;
  logic [XLEN-1:0] load_data;

  always_comb begin
    mem_load = ~mem_bubble & ~|mem_exception & op_is_load(mem_instr);
    stall    = mem_load & ~dmem_ack & ~flush;
  end

  mwb_mem_stage #(.XLEN(XLEN), .EXC_W(EXC_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .flush(flush), .stall(stall),
    .ex_result(ex_result), .ex_pc(ex_pc), .ex_instr(ex_instr),
    .ex_bubble(ex_bubble), .ex_exception(ex_exception),
    .mem_result(mem_result), .mem_pc(mem_pc), .mem_instr(mem_instr),
    .mem_bubble(mem_bubble), .mem_exception(mem_exception)
  );

  mwb_load_align #(.XLEN(XLEN)) u_align (
    .rdata(dmem_q), .addr_lo(mem_result[LSB_W-1:0]),
    .funct3(mem_instr[14:12]), .ldata(load_data)
  );

  mwb_wb_stage #(.XLEN(XLEN), .EXC_W(EXC_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .kill(flush | stall), .mem_load(mem_load),
    .load_data(load_data), .mem_result(mem_result), .mem_pc(mem_pc),
    .mem_instr(mem_instr), .mem_bubble(mem_bubble), .mem_exception(mem_exception),
    .wb_result(wb_result), .wb_dst(wb_dst), .wb_we(wb_we), .wb_pc(wb_pc),
    .wb_instr(wb_instr), .wb_bubble(wb_bubble), .wb_exception(wb_exception)
  );

  a_r6_stall_is_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (mem_instr[6:0] == 7'b0000011 && !mem_bubble));

  a_r6_stall_bubbles_wb: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> wb_bubble);

  a_r10_exc_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_exception != '0) |-> !stall);

  a_r4_we_needs_dst: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_instr[11:7] != 5'd0 && !wb_bubble));

endmodule

// File: tb/mwb_backend_tb.sv
`timescale 1ns/1ps
module mwb_backend_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [31:0] ex_result, ex_pc, ex_instr, dmem_q;
  logic        ex_bubble, dmem_ack;
  logic [3:0]  ex_exception;
  logic        stall, mem_bubble, wb_we, wb_bubble;
  logic [31:0] mem_result, mem_instr, mem_pc, wb_result, wb_pc, wb_instr;
  logic [3:0]  mem_exception, wb_exception;
  logic [4:0]  wb_dst;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mwb_backend u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ex_result(ex_result), .ex_pc(ex_pc),
    .ex_instr(ex_instr), .ex_bubble(ex_bubble), .ex_exception(ex_exception),
    .dmem_q(dmem_q), .dmem_ack(dmem_ack), .stall(stall), .mem_result(mem_result),
    .mem_instr(mem_instr), .mem_pc(mem_pc), .mem_bubble(mem_bubble),
    .mem_exception(mem_exception), .wb_result(wb_result), .wb_dst(wb_dst),
    .wb_we(wb_we), .wb_pc(wb_pc), .wb_instr(wb_instr), .wb_bubble(wb_bubble),
    .wb_exception(wb_exception)
  );

  // model state
  logic [31:0] m_res, m_pc, m_ins, w_res, w_pc, w_ins;
  logic        m_bub, w_bub;
  logic [3:0]  m_exc, w_exc;

  function automatic logic [31:0] ext(input logic [31:0] q, input logic [1:0] a,
                                      input logic [2:0] f3);
    logic [31:0] s;
    s = q >> (a * 8);
    case (f3)
      3'b000: return {{24{s[7]}}, s[7:0]};
      3'b001: return {{16{s[15]}}, s[15:0]};
      3'b100: return {24'd0, s[7:0]};
      3'b101: return {16'd0, s[15:0]};
      default: return s;
    endcase
  endfunction

  function automatic logic wr_rd(input logic [31:0] i);
    case (i[6:0])
      7'h03, 7'h13, 7'h17, 7'h33, 7'h37, 7'h67, 7'h6f, 7'h1b, 7'h3b: return 1'b1;
      7'h73: return i[14:12] != 3'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_load();
    return !m_bub && m_exc == 4'd0 && m_ins[6:0] == 7'h03;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs already set after a negedge; compare, then advance one clock
  task automatic step();
    logic st, we;
    #1;
    st = m_load() && !dmem_ack && !flush;
    we = !w_bub && w_exc == 4'd0 && wr_rd(w_ins) && w_ins[11:7] != 5'd0;
    chk("R6 stall", {31'd0, stall}, {31'd0, st});
    chk("R2 mem_bubble", {31'd0, mem_bubble}, {31'd0, m_bub});
    if (!m_bub) begin
      chk("R2 mem_pc", mem_pc, m_pc);
      chk("R2 mem_result", mem_result, m_res);
      chk("R2 mem_instr", mem_instr, m_ins);
      chk("R10 mem_exception", {28'd0, mem_exception}, {28'd0, m_exc});
    end
    chk("R9 wb_bubble", {31'd0, wb_bubble}, {31'd0, w_bub});
    chk("R4 wb_we", {31'd0, wb_we}, {31'd0, we});
    chk("R5 wb_dst", {27'd0, wb_dst}, {27'd0, wb_instr[11:7]});
    if (!w_bub) begin
      chk("R7 R3 wb_result", wb_result, w_res);
      chk("R3 wb_pc", wb_pc, w_pc);
      chk("R10 wb_exception", {28'd0, wb_exception}, {28'd0, w_exc});
    end
    @(posedge clk);
    w_bub = m_bub | flush | st;
    w_exc = (flush | st) ? 4'd0 : m_exc;
    w_res = m_load() ? ext(dmem_q, m_res[1:0], m_ins[14:12]) : m_res;
    w_pc  = m_pc;
    w_ins = m_ins;
    if (flush) begin
      m_bub = 1'b1; m_exc = 4'd0;
      m_res = ex_result; m_pc = ex_pc; m_ins = ex_instr;
    end else if (!st) begin
      m_bub = ex_bubble; m_exc = ex_exception;
      m_res = ex_result; m_pc = ex_pc; m_ins = ex_instr;
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    flush = 0; ex_bubble = 1; ex_exception = 0; ex_instr = 32'h13;
    ex_result = 0; ex_pc = 0; dmem_q = 0; dmem_ack = 0;
  endtask

  // R8 directed load: issue, answer with ack, check extended value
  task automatic dir_load(input logic [2:0] f3, input logic [1:0] a,
                          input logic [31:0] q, input logic [31:0] exp);
    idle_in();
    ex_bubble = 0; ex_instr = {17'd0, f3, 5'd9, 7'h03}; ex_result = {30'h100, a};
    ex_pc = 32'h400;
    step();
    idle_in(); dmem_q = q; dmem_ack = 1;
    step();
    idle_in();
    #1;
    chk("R8 extended load data", wb_result, exp);
    chk("R8 load write enable", {31'd0, wb_we}, 32'd1);
    step();
  endtask

  function automatic logic [31:0] rnd_instr();
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] pool [13] = '{7'h03, 7'h13, 7'h33, 7'h37, 7'h17, 7'h6f, 7'h67,
                              7'h23, 7'h63, 7'h73, 7'h0f, 7'h1b, 7'h3b};
    opc = pool[$urandom_range(0, 12)];
    f3 = 3'($urandom);
    if (opc == 7'h03) begin
      logic [2:0] lf [5] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
      f3 = lf[$urandom_range(0, 4)];
    end
    return {17'($urandom), f3, ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom), opc};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle_in();
    rst_n = 0;
    m_bub = 1; w_bub = 1; m_exc = 0; w_exc = 0;
    m_res = 0; m_pc = 0; m_ins = 0; w_res = 0; w_pc = 0; w_ins = 0;
    #12;
    @(negedge clk);
    chk("R1 reset mem_bubble", {31'd0, mem_bubble}, 32'd1);
    chk("R1 reset wb_bubble", {31'd0, wb_bubble}, 32'd1);
    chk("R1 reset wb_we", {31'd0, wb_we}, 32'd0);
    chk("R1 reset stall", {31'd0, stall}, 32'd0);
    rst_n = 1;
    step();

    dir_load(3'b000, 2'd3, 32'h80_12_34_56, 32'hFFFF_FF80);
    dir_load(3'b100, 2'd3, 32'h80_12_34_56, 32'h0000_0080);
    dir_load(3'b001, 2'd2, 32'h9234_5678, 32'hFFFF_9234);
    dir_load(3'b101, 2'd0, 32'h1234_F678, 32'h0000_F678);
    dir_load(3'b010, 2'd0, 32'hCAFE_BABE, 32'hCAFE_BABE);

    // R6: load waits two cycles without ack, then completes
    idle_in(); ex_bubble = 0; ex_instr = {17'd0, 3'b010, 5'd4, 7'h03}; ex_result = 32'h200;
    step();
    idle_in(); ex_bubble = 0; ex_instr = 32'h0030_0293; // addi-like, held upstream
    step(); step();
    dmem_ack = 1; dmem_q = 32'h1111_2222;
    step();
    idle_in(); #1;
    chk("R6 R7 load after wait", wb_result, 32'h1111_2222);
    step();

    // R9 flush collides with a waiting load
    idle_in(); ex_bubble = 0; ex_instr = {17'd0, 3'b000, 5'd6, 7'h03}; ex_result = 32'h300;
    step();
    idle_in(); flush = 1;
    step();
    idle_in(); #1;
    chk("R9 flushed load no write", {31'd0, wb_we}, 32'd0);
    step();

    // R10 excepting load never stalls
    idle_in(); ex_bubble = 0; ex_exception = 4'h2; ex_instr = {17'd0, 3'b000, 5'd7, 7'h03};
    step();
    idle_in(); #1;
    chk("R10 excepting load no stall", {31'd0, stall}, 32'd0);
    step();
    #1;
    chk("R10 excepting load no write", {31'd0, wb_we}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      if (!stall || $urandom_range(0, 3) == 0) begin
        ex_instr = rnd_instr();
        ex_result = $urandom; ex_pc = $urandom;
        ex_bubble = $urandom_range(0, 9) == 0;
        ex_exception = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
      end
      dmem_q = $urandom;
      dmem_ack = $urandom_range(0, 2) != 0;
      flush = $urandom_range(0, 19) == 0;
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule